// File: doc/BRIEF.md
# Bidirectional Universal Bus Register

This block moves data between two 18-bit ports, A and B, with one independent path in each direction. Each path has four controls: an active-low output enable, an active-high latch enable, an active-low clock enable and a path clock. Together they select a transfer mode. In transparent mode the output follows the input. In latched mode the stored word is held. In clocked mode the input is captured on a rising path-clock edge. The clock enable decides whether such an edge is acted on at all.

The block is written for a synchronous fabric. All inputs, the path clocks included, are sampled on the single system clock `clk`. A path-clock rising edge is a low sample followed by a high sample. The stored word drives the opposite port directly from a register, so a transparent path has one `clk` cycle of latency. The tri-state of each output port is given as a data bus plus a separate registered drive-enable bit. Reset is synchronous and active high.

Top module: `ubus_reg`

## Requirements
- R1: While `rst` is high at a `clk` edge, both stored words become zero and both drive enables (`b_drv`, `a_drv`) become 0.
- R2: With the latch enable high at a `clk` edge, the output data equals the input sampled at that edge, from the following cycle on (transparent mode).
- R3: With the latch enable low and no path-clock rising edge between two samples, the output data is unchanged, whatever the input does.
- R4: With the latch enable low and the clock enable low (0 = enabled), a path clock sampled 0 and then 1 on consecutive `clk` edges stores the input present at the second edge.
- R5: With the clock enable high (1 = disabled), a path-clock rising edge leaves the stored word unchanged.
- R6: The drive enable equals the inverse of the output-enable input sampled at the previous `clk` edge. Output enable 1 means not driven.
- R7: Disabling the output does not alter the stored word. Re-enabling shows the word stored before the disable.
- R8: The A-to-B path (controls `ab_*`, data `a_in` to `b_out`) and the B-to-A path (controls `ba_*`, data `b_in` to `a_out`) are independent. No control of one path affects the other.
- R9: When the latch enable falls, the word captured at the last transparent edge is held until the next enabled rising edge or the next transparent cycle.
- R10: A path clock held high through reset and still high after reset is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data arriving on port A |
| b_in | input | 18 | Data arriving on port B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, high = transparent |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_clk | input | 1 | A-to-B path clock (sampled level) |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, high = transparent |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_clk | input | 1 | B-to-A path clock (sampled level) |
| b_out | output | 18 | Data driven onto port B |
| b_drv | output | 1 | Drive enable for `b_out`, 1 = driven |
| a_out | output | 18 | Data driven onto port A |
| a_drv | output | 1 | Drive enable for `a_out`, 1 = driven |

## Verification
The bench runs a reference model alongside the design. It feeds both paths from a vector table with different control phases, so a design that crossed path controls would diverge on one port. Edge cases are aimed at directly:

- A disabled clock edge: a design that ignored the clock enable would capture there.
- A falling latch enable followed by input changes: a design that stayed transparent would follow the input.
- A high path clock across the release of reset: a naive edge detector would see a false edge.
- An output disabled and re-enabled: a design that cleared or reloaded storage on disable would lose the word.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  localparam int unsigned LANES = 2;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_PASS  = 2'd1,
    MODE_CLOCK = 2'd2
  } ubr_mode_e;
endpackage

// File: rtl/ubr_edge.sv
module ubr_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  // During reset the previous sample tracks the level, so a level held
  // high across reset release is not mistaken for an edge.
  always_ff @(posedge clk) begin
    lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q & ~rst;
endmodule

// File: rtl/ubr_store.sv
module ubr_store
  import ubr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  ubr_mode_e    mode,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (mode)
        MODE_PASS, MODE_CLOCK: q <= din;
        default:               q <= q;
      endcase
    end
  end
endmodule

// File: rtl/ubr_drive.sv
module ubr_drive (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  output logic drv
);
  always_ff @(posedge clk) begin
    if (rst) drv <= 1'b0;
    else     drv <= ~oe_n;
  end
endmodule

// File: rtl/ubr_lane.sv
module ubr_lane
  import ubr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         oe_n,
  input  logic         le,
  input  logic         ce_n,
  input  logic         pclk,
  output logic [W-1:0] dout,
  output logic         drv
);
  logic      rise;
  ubr_mode_e mode;

  ubr_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pclk),
    .rise (rise)
  );

  // Latch enable wins; otherwise only a gated rising edge captures.
  always_comb begin
    if (le)                mode = MODE_PASS;
    else if (rise & ~ce_n) mode = MODE_CLOCK;
    else                   mode = MODE_HOLD;
  end

  ubr_store #(.W(W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .mode (mode),
    .q    (dout)
  );

  ubr_drive u_drive (
    .clk  (clk),
    .rst  (rst),
    .oe_n (oe_n),
    .drv  (drv)
  );
endmodule

// File: rtl/ubus_reg.sv
module ubus_reg
  import ubr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_ce_n,
  input  logic         ab_clk,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_ce_n,
  input  logic         ba_clk,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  output logic [W-1:0] a_out,
  output logic         a_drv
);
  // Lane 0 carries A to B, lane 1 carries B to A.
  logic [W-1:0] l_din  [LANES];
  logic [W-1:0] l_dout [LANES];
  logic [LANES-1:0] l_oe_n, l_le, l_ce_n, l_pclk, l_drv;

  assign l_din[0] = a_in;
  assign l_din[1] = b_in;
  assign l_oe_n   = {ba_oe_n, ab_oe_n};
  assign l_le     = {ba_le,   ab_le};
  assign l_ce_n   = {ba_ce_n, ab_ce_n};
  assign l_pclk   = {ba_clk,  ab_clk};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ubr_lane #(.W(W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .din  (l_din[g]),
      .oe_n (l_oe_n[g]),
      .le   (l_le[g]),
      .ce_n (l_ce_n[g]),
      .pclk (l_pclk[g]),
      .dout (l_dout[g]),
      .drv  (l_drv[g])
    );
  end

  assign b_out = l_dout[0];
  assign b_drv = l_drv[0];
  assign a_out = l_dout[1];
  assign a_drv = l_drv[1];
endmodule

// File: rtl/ubus_reg_chk.sv
module ubus_reg_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_oe_n,
  input logic         ab_le,
  input logic         ab_ce_n,
  input logic         ab_clk,
  input logic         ba_oe_n,
  input logic         ba_le,
  input logic         ba_ce_n,
  input logic         ba_clk,
  input logic [W-1:0] b_out,
  input logic         b_drv,
  input logic [W-1:0] a_out,
  input logic         a_drv
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (b_out == '0 && a_out == '0 && !b_drv && !a_drv));

  p_pass_ab_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ab_le)) |-> (b_out == $past(a_in)));
  p_pass_ba_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ba_le)) |-> (a_out == $past(b_in)));

  p_hold_ab_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ab_le) &&
     !(!$past(ab_ce_n) && $past(ab_clk) && !$past(ab_clk, 2))) |-> $stable(b_out));
  p_hold_ba_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ba_le) &&
     !(!$past(ba_ce_n) && $past(ba_clk) && !$past(ba_clk, 2))) |-> $stable(a_out));

  p_clock_ab_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ab_le) && !$past(ab_ce_n) && $past(ab_clk) && !$past(ab_clk, 2))
      |-> (b_out == $past(a_in)));
  p_clock_ba_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ba_le) && !$past(ba_ce_n) && $past(ba_clk) && !$past(ba_clk, 2))
      |-> (a_out == $past(b_in)));

  p_drive_ab_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (b_drv == !$past(ab_oe_n)));
  p_drive_ba_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (a_drv == !$past(ba_oe_n)));
endmodule

bind ubus_reg ubus_reg_chk #(.W(W)) u_ubus_reg_chk (.*);

// File: tb/test_ubus_reg.sv
module test_ubus_reg;
  localparam int unsigned W      = 18;
  localparam time         PERIOD = 10ns;
  localparam int unsigned NV     = 24;
  // Vector layout: {le, ce_n, pclk, oe_n, data[17:0]}
  localparam logic [W+3:0] VEC [NV] = '{
    {4'b1000, 18'h12345}, {4'b1000, 18'h2ABCD}, {4'b0000, 18'h00F0F},
    {4'b0000, 18'h3FFFF}, {4'b0010, 18'h1111F}, {4'b0010, 18'h22220},
    {4'b0000, 18'h03333}, {4'b0100, 18'h04444}, {4'b0110, 18'h05555},
    {4'b0110, 18'h06666}, {4'b0000, 18'h07777}, {4'b0011, 18'h08888},
    {4'b0001, 18'h09999}, {4'b1001, 18'h0AAAA}, {4'b1000, 18'h0BBBB},
    {4'b0010, 18'h0CCCC}, {4'b0100, 18'h0DDDD}, {4'b0010, 18'h0EEEE},
    {4'b1110, 18'h0F00F}, {4'b0100, 18'h10101}, {4'b0110, 18'h20202},
    {4'b0000, 18'h30303}, {4'b0010, 18'h00001}, {4'b0000, 18'h00002}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_ce_n = 1'b1, ab_clk = 1'b0;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_ce_n = 1'b1, ba_clk = 1'b0;
  logic [W-1:0] b_out, a_out;
  logic         b_drv, a_drv;

  int n_chk = 0;
  int n_bad = 0;

  // Reference model state, index 0 = A to B, 1 = B to A
  logic [W-1:0] m_st   [2];
  logic         m_prev [2];
  logic         m_drv  [2];
  logic         m_le_q [2];

  always #(PERIOD/2) clk = ~clk;

  ubus_reg #(.W(W)) i_ubus_reg (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_ce_n(ab_ce_n), .ab_clk(ab_clk),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ce_n(ba_ce_n), .ba_clk(ba_clk),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_step(input int d, input logic [W-1:0] din,
                                     input logic le, input logic ce_n,
                                     input logic pclk, input logic oe_n);
    if (rst) begin
      m_st[d] = '0; m_drv[d] = 1'b0;
    end else begin
      if (le) m_st[d] = din;
      else if (!ce_n && pclk && !m_prev[d]) m_st[d] = din;
      m_drv[d] = !oe_n;
    end
    m_prev[d] = pclk;
    m_le_q[d] = le;
  endfunction

  // One system clock: model follows the sampled inputs, then settle.
  task automatic cyc();
    @(posedge clk);
    model_step(0, a_in, ab_le, ab_ce_n, ab_clk, ab_oe_n);
    model_step(1, b_in, ba_le, ba_ce_n, ba_clk, ba_oe_n);
    #1;
  endtask

  function automatic string tag_of(input logic le, input logic ce_n,
                                   input logic pclk, input logic prev, input logic le_q);
    if (le) return "R2";
    if (le_q) return "R9";
    if (pclk && !prev && !ce_n) return "R4";
    if (pclk && !prev) return "R5";
    return "R3";
  endfunction

  initial begin
    #(PERIOD * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    string t;
    logic [W-1:0] keep;
    for (int d = 0; d < 2; d++) begin
      m_st[d] = '0; m_prev[d] = 1'b0; m_drv[d] = 1'b0; m_le_q[d] = 1'b0;
    end
    // Reset with path clocks high and capture armed (R10 setup)
    ab_clk = 1'b1; ba_clk = 1'b1; ab_le = 1'b0; ba_le = 1'b0;
    ab_ce_n = 1'b0; ba_ce_n = 1'b0; ab_oe_n = 1'b0; ba_oe_n = 1'b0;
    a_in = 18'h15A5A; b_in = 18'h0A5A5;
    repeat (3) cyc();
    chk("R1 b_out", b_out, 0); chk("R1 a_out", a_out, 0);
    chk("R1 b_drv", b_drv, 0); chk("R1 a_drv", a_drv, 0);
    rst = 1'b0;
    a_in = 18'h3FFFF; b_in = 18'h3FFFE;
    cyc(); cyc();
    chk("R10 b_out", b_out, 0); chk("R10 a_out", a_out, 0);
    chk("R6 b_drv", b_drv, 1); chk("R6 a_drv", a_drv, 1);

    // Table walk: B-to-A uses a shifted control phase (R8)
    for (int i = 0; i < NV; i++) begin
      logic [W+3:0] va, vb;
      logic pa, pb, la, lb;
      va = VEC[i];
      vb = VEC[(i + 7) % NV];
      pa = m_prev[0]; pb = m_prev[1]; la = m_le_q[0]; lb = m_le_q[1];
      {ab_le, ab_ce_n, ab_clk, ab_oe_n} = va[W+3:W];
      a_in = va[W-1:0];
      {ba_le, ba_ce_n, ba_clk, ba_oe_n} = vb[W+3:W];
      b_in = vb[W-1:0] ^ 18'h2AAAA;
      cyc();
      t = tag_of(va[W+3], va[W+2], va[W+1], pa, la);
      chk({t, " b_out"}, b_out, m_st[0]);
      chk("R6 b_drv", b_drv, m_drv[0]);
      t = tag_of(vb[W+3], vb[W+2], vb[W+1], pb, lb);
      chk({"R8 ", t, " a_out"}, a_out, m_st[1]);
      chk("R8 R6 a_drv", a_drv, m_drv[1]);
    end

    // R7: disable keeps storage, re-enable shows it
    ab_le = 1'b1; ab_oe_n = 1'b0; a_in = 18'h1C3C3; cyc();
    keep = 18'h1C3C3;
    ab_le = 1'b0; ab_ce_n = 1'b1; ab_oe_n = 1'b1; a_in = 18'h00000; cyc();
    chk("R7 b_drv off", b_drv, 0);
    ab_clk = 1'b0; cyc(); ab_clk = 1'b1; a_in = 18'h3000F; cyc();
    chk("R5 b_out under ce_n high", b_out, keep);
    ab_oe_n = 1'b0; cyc();
    chk("R7 b_drv on", b_drv, 1);
    chk("R7 b_out kept", b_out, keep);
    chk("R8 a_out untouched", a_out, m_st[1]);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule